// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block models the command front end of a word-wide parallel NOR flash in a synchronous form. It watches a stream of single-cycle write beats, each carrying an address and a 16-bit data word, and recognises the keyed multi-beat sequences that start a word program, a sector erase, a block erase or a whole-array erase. It also recognises the sequences that enter and leave the identification and query sub-modes. A recognised program or erase produces a one-cycle request carrying the operation kind, its aligned address and its data. The request goes to an array model outside this block.

Each request starts a simulated internal operation. It lasts a fixed number of clock cycles, set by a parameter for each operation kind. While it runs the block reports a busy mode and ignores every write beat. Outside busy the block reports read, identification or query mode. In identification and query mode, a read address port returns the identifier words or the query string.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` reads 0 and `op_req` is low. The `mode` encoding is 0 = read, 1 = identification, 2 = query, 3 = busy. In read mode `rd_data` is 0000h.
- R2: The beats AAh@5555h, 55h@2AAAh, A0h@5555h followed by any fourth beat raise `op_req` for one cycle in the cycle after that fourth beat. That cycle carries `op_kind` = 0 (program), `op_addr` equal to the fourth beat's address and `op_data` equal to its data. The `op_kind` encoding is 0 program, 1 sector, 2 block, 3 chip.
- R3: The beats AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address, give a request with `op_kind` = 1. Its `op_addr` is that address with bits 10..0 cleared.
- R4: The same five-beat prefix followed by 50h at any address gives `op_kind` = 2. Its `op_addr` is that address with bits 14..0 cleared.
- R5: The prefix followed by 10h@5555h gives `op_kind` = 3 with `op_addr` 0. If 10h goes to any other address, the sequence aborts with no request.
- R6: Sequence matching compares only address bits 14..0 and data bits 7..0. Higher address bits and data bits 15..8 never affect the decode.
- R7: A beat that does not fit the next step of a sequence returns the decoder to its idle step with no request. A later continuation of the broken sequence then starts nothing.
- R8: From the cycle in which `op_req` is high, `mode` stays 3 for exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles, according to the operation kind. A write beat in the last busy cycle is ignored. A beat in the first cycle after busy is decoded.
- R9: While `mode` is 3, every write beat is ignored, including exit beats. No request is raised and sequence progress does not advance.
- R10: The beats AAh@5555h, 55h@2AAAh, 90h@5555h enter identification mode. There `rd_data` is MFR_CODE (00BFh) at address 0, DEV_CODE at address 1, and 0000h elsewhere.
- R11: The beats AAh@5555h, 55h@2AAAh, 98h@5555h enter query mode. There `rd_data` is 0051h, 0052h and 0059h at addresses 10h, 11h and 12h, and 0000h elsewhere.
- R12: In identification or query mode, a single F0h beat at any address returns to read mode, and so does AAh@5555h, 55h@2AAAh, F0h@5555h. Any other beat leaves the sub-mode in place and starts no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write beat strobe |
| wr_addr | input | ADDR_W | Write beat word address |
| wr_data | input | 16 | Write beat data |
| rd_addr | input | ADDR_W | Identification/query read address |
| rd_data | output | 16 | Identification/query read data |
| mode | output | 2 | Current mode (0 read, 1 ID, 2 query, 3 busy) |
| op_req | output | 1 | One-cycle program/erase request |
| op_kind | output | 2 | Request kind (0 program, 1 sector, 2 block, 3 chip) |
| op_addr | output | ADDR_W | Request address, aligned for erases |
| op_data | output | 16 | Request data (FFFFh for erases) |

## Verification
The end of a busy interval and the arrival of a write beat can fall in the same clock edge, and that edge decides whether the beat is decoded. The bench counts the cycles after a request and places an unlock beat exactly in the last busy cycle. It then completes a program sequence and requires that no request appears, which shows the early beat was dropped. A second run places the first beat in the first cycle after busy and requires a request.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_UNL1  = 8'hAA;
    localparam logic [7:0] CODE_UNL2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_ID    = 8'h90;
    localparam logic [7:0] CODE_QRY   = 8'h98;
    localparam logic [7:0] CODE_EXIT  = 8'hF0;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_BLK   = 8'h50;
    localparam logic [7:0] CODE_CHIP  = 8'h10;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2,
        MODE_BUSY  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3
    } seq_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [7:0]       code;
    } beat_t;

    function automatic logic beat_is(beat_t b, logic [KEY_W-1:0] k, logic [7:0] c);
        return (b.key == k) && (b.code == c);
    endfunction

    // Query string word for offset 0..2 past the query base
    function automatic logic [15:0] qry_word(logic [1:0] idx);
        case (idx)
            2'd0:    return 16'h0051;
            2'd1:    return 16'h0052;
            2'd2:    return 16'h0059;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
    import nor_cmd_pkg::*;
#(
    parameter int PROG_CYC = 12,
    parameter int SECT_CYC = 20,
    parameter int BLK_CYC  = 24,
    parameter int CHIP_CYC = 28
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     start_i,
    input  op_kind_e kind_i,
    output logic     busy_o
);
    localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_CD = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load;

    always_comb begin
        case (kind_i)
            OP_PROG: load = CNT_W'(PROG_CYC);
            OP_SECT: load = CNT_W'(SECT_CYC);
            OP_BLK:  load = CNT_W'(BLK_CYC);
            default: load = CNT_W'(CHIP_CYC);
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);

    // R8
    start_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> busy_o);

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic              busy_i,
    output mode_e             base_mode_o,
    output logic              start_o,
    output op_kind_e          start_kind_o,
    output logic              req_o,
    output op_kind_e          req_kind_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [15:0]       req_data_o
);
    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));

    seq_e              seq_q, seq_n;
    mode_e             base_q, base_n;
    logic              req_n;
    op_kind_e          kind_n;
    logic [ADDR_W-1:0] addr_n;
    logic [15:0]       data_n;
    logic              accept;
    beat_t             beat;
    logic              unl1, unl2;

    assign accept = wr_stb_i && !busy_i;
    assign beat   = '{key: wr_addr_i[KEY_W-1:0], code: wr_data_i[7:0]};
    assign unl1   = beat_is(beat, KEY_ADDR_A, CODE_UNL1);
    assign unl2   = beat_is(beat, KEY_ADDR_B, CODE_UNL2);

    always_comb begin
        seq_n  = seq_q;
        base_n = base_q;
        req_n  = 1'b0;
        kind_n = OP_PROG;
        addr_n = '0;
        data_n = '0;
        if (accept) begin
            if (base_q != MODE_READ) begin
                // Sub-mode: only exits are honoured
                if (beat.code == CODE_EXIT) begin
                    base_n = MODE_READ;
                    seq_n  = SQ_IDLE;
                end else if (seq_q == SQ_IDLE && unl1) begin
                    seq_n = SQ_UNL1;
                end else if (seq_q == SQ_UNL1 && unl2) begin
                    seq_n = SQ_UNL2;
                end else begin
                    seq_n = SQ_IDLE;
                end
            end else begin
                seq_n = SQ_IDLE;
                case (seq_q)
                    SQ_IDLE: if (unl1) seq_n = SQ_UNL1;
                    SQ_UNL1: if (unl2) seq_n = SQ_UNL2;
                    SQ_UNL2: begin
                        if (beat.key == KEY_ADDR_A) begin
                            case (beat.code)
                                CODE_PROG:  seq_n  = SQ_PROG;
                                CODE_ERASE: seq_n  = SQ_ERA1;
                                CODE_ID:    base_n = MODE_ID;
                                CODE_QRY:   base_n = MODE_QUERY;
                                default:    seq_n  = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PROG: begin
                        req_n  = 1'b1;
                        kind_n = OP_PROG;
                        addr_n = wr_addr_i;
                        data_n = wr_data_i;
                    end
                    SQ_ERA1: if (unl1) seq_n = SQ_ERA2;
                    SQ_ERA2: if (unl2) seq_n = SQ_ERA3;
                    SQ_ERA3: begin
                        if (beat.code == CODE_SECT) begin
                            req_n  = 1'b1;
                            kind_n = OP_SECT;
                            addr_n = wr_addr_i & SECT_MASK;
                            data_n = 16'hFFFF;
                        end else if (beat.code == CODE_BLK) begin
                            req_n  = 1'b1;
                            kind_n = OP_BLK;
                            addr_n = wr_addr_i & BLK_MASK;
                            data_n = 16'hFFFF;
                        end else if (beat_is(beat, KEY_ADDR_A, CODE_CHIP)) begin
                            req_n  = 1'b1;
                            kind_n = OP_CHIP;
                            addr_n = '0;
                            data_n = 16'hFFFF;
                        end
                    end
                    default: seq_n = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q      <= SQ_IDLE;
            base_q     <= MODE_READ;
            req_o      <= 1'b0;
            req_kind_o <= OP_PROG;
            req_addr_o <= '0;
            req_data_o <= '0;
        end else begin
            seq_q      <= seq_n;
            base_q     <= base_n;
            req_o      <= req_n;
            req_kind_o <= kind_n;
            req_addr_o <= addr_n;
            req_data_o <= data_n;
        end
    end

    assign base_mode_o  = base_q;
    assign start_o      = req_n;
    assign start_kind_o = kind_n;

    // R9
    busy_no_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |=> !req_o);

    // R12
    sub_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (base_q != MODE_READ && wr_stb_i && !busy_i && wr_data_i[7:0] == CODE_EXIT)
        |=> base_q == MODE_READ);

    // R3
    sect_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && req_kind_o == OP_SECT) |-> (req_addr_o & ~SECT_MASK) == '0);

    // R4
    blk_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && req_kind_o == OP_BLK) |-> (req_addr_o & ~BLK_MASK) == '0);

endmodule

// File: rtl/nor_id_rom.sv
module nor_id_rom
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter logic [15:0] MFR_CODE = 16'h00BF,
    parameter logic [15:0] DEV_CODE = 16'h00C3,
    parameter int          QRY_BASE = 16
) (
    input  mode_e             mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_data_o
);
    logic [ADDR_W-1:0] qry_off;

    assign qry_off = rd_addr_i - ADDR_W'(QRY_BASE);

    always_comb begin
        rd_data_o = '0;
        case (mode_i)
            MODE_ID: begin
                if (rd_addr_i == ADDR_W'(0))      rd_data_o = MFR_CODE;
                else if (rd_addr_i == ADDR_W'(1)) rd_data_o = DEV_CODE;
            end
            MODE_QUERY: begin
                if (qry_off < ADDR_W'(3)) rd_data_o = qry_word(qry_off[1:0]);
            end
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          SECT_LSB = 11,
    parameter int          BLK_LSB  = 15,
    parameter int          PROG_CYC = 12,
    parameter int          SECT_CYC = 20,
    parameter int          BLK_CYC  = 24,
    parameter int          CHIP_CYC = 28,
    parameter logic [15:0] MFR_CODE = 16'h00BF,
    parameter logic [15:0] DEV_CODE = 16'h00C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic [1:0]        mode,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    mode_e    base_mode;
    mode_e    cur_mode;
    logic     busy;
    logic     start;
    op_kind_e start_kind;
    op_kind_e req_kind;

    nor_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .SECT_LSB (SECT_LSB),
        .BLK_LSB  (BLK_LSB)
    ) u_fsm (
        .clk_i        (clk),
        .rst_i        (rst),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .busy_i       (busy),
        .base_mode_o  (base_mode),
        .start_o      (start),
        .start_kind_o (start_kind),
        .req_o        (op_req),
        .req_kind_o   (req_kind),
        .req_addr_o   (op_addr),
        .req_data_o   (op_data)
    );

    nor_busy_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLK_CYC  (BLK_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .kind_i  (start_kind),
        .busy_o  (busy)
    );

    assign cur_mode = busy ? MODE_BUSY : base_mode;

    nor_id_rom #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rom (
        .mode_i    (cur_mode),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    assign mode    = cur_mode;
    assign op_kind = req_kind;

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_req |-> cur_mode == MODE_BUSY);

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int P_PROG = 12;
    localparam int P_SECT = 20;
    localparam int P_BLK  = 24;
    localparam int P_CHIP = 28;
    localparam logic [15:0] DEV = 16'h00C3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic [1:0]    mode;
    logic          op_req;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;

    int total = 0;
    int fails = 0;
    logic          req_seen;
    logic [1:0]    got_kind;
    logic [AW-1:0] got_addr;
    logic [15:0]   got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder #(
        .ADDR_W (AW), .PROG_CYC (P_PROG), .SECT_CYC (P_SECT),
        .BLK_CYC (P_BLK), .CHIP_CYC (P_CHIP), .DEV_CODE (DEV)
    ) u_nor_cmd_decoder (
        .clk (clk), .rst (rst), .wr_stb (wr_stb), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .mode (mode), .op_req (op_req), .op_kind (op_kind),
        .op_addr (op_addr), .op_data (op_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Caller is at a falling edge; beat sampled at the next rising edge
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
        if (op_req) begin
            req_seen = 1'b1; got_kind = op_kind; got_addr = op_addr; got_data = op_data;
        end
    endtask

    task automatic unlock();
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(19'h05555, 16'h0080);
        unlock();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && mode == 2'd3; i++) @(negedge clk);
    endtask

    task automatic busy_len(input string tag, input int exp);
        int n = 0;
        while (mode == 2'd3 && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(tag, n, exp);
    endtask

    task automatic t_reset();
        rd_addr = '0;
        chk("R1 reset mode", mode, 2'd0);
        chk("R1 reset op_req", op_req, 1'b0);
        chk("R1 reset rd_data", rd_data, 16'h0000);
    endtask

    task automatic t_program();
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        chk("R2 no req before data beat", req_seen, 1'b0);
        wr(19'h4_1234, 16'hBEEF);
        chk("R2 program req", req_seen, 1'b1);
        chk("R2 program kind", got_kind, 2'd0);
        chk("R2 program addr", got_addr, 19'h4_1234);
        chk("R2 program data", got_data, 16'hBEEF);
        busy_len("R8 program busy length", P_PROG);
        chk("R8 mode read after program", mode, 2'd0);
    endtask

    task automatic t_sector();
        req_seen = 1'b0;
        erase_prefix();
        wr(19'h5_4ABC, 16'h0030);
        chk("R3 sector req", req_seen, 1'b1);
        chk("R3 sector kind", got_kind, 2'd1);
        chk("R3 sector addr", got_addr, 19'h5_4800);
        busy_len("R8 sector busy length", P_SECT);
    endtask

    task automatic t_block();
        req_seen = 1'b0;
        erase_prefix();
        wr(19'h6_ABCD, 16'h0050);
        chk("R4 block req", req_seen, 1'b1);
        chk("R4 block kind", got_kind, 2'd2);
        chk("R4 block addr", got_addr, 19'h6_8000);
        busy_len("R8 block busy length", P_BLK);
    endtask

    task automatic t_chip();
        req_seen = 1'b0;
        erase_prefix();
        wr(19'h01234, 16'h0010);
        chk("R5 chip code at wrong address no req", req_seen, 1'b0);
        chk("R5 mode read after bad chip", mode, 2'd0);
        erase_prefix();
        wr(19'h05555, 16'h0010);
        chk("R5 chip req", req_seen, 1'b1);
        chk("R5 chip kind", got_kind, 2'd3);
        chk("R5 chip addr", got_addr, 19'h0);
        busy_len("R8 chip busy length", P_CHIP);
    endtask

    task automatic t_dont_care();
        req_seen = 1'b0;
        wr(19'h7_D555, 16'h12AA);
        wr(19'h2_2AAA, 16'hFF55);
        wr(19'h3_5555, 16'hC3A0);
        wr(19'h00042, 16'h1111);
        chk("R6 upper bits ignored req", req_seen, 1'b1);
        chk("R6 upper bits ignored data", got_data, 16'h1111);
        wait_idle();
        req_seen = 1'b0;
        wr(19'h05554, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, 16'h00A0);
        wr(19'h00042, 16'h2222);
        chk("R6 low bit mismatch no req", req_seen, 1'b0);
    endtask

    task automatic t_abort();
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h0033);
        wr(19'h05555, 16'h00A0);
        wr(19'h00010, 16'h3333);
        chk("R7 abort then program tail no req", req_seen, 1'b0);
        chk("R7 mode read after abort", mode, 2'd0);
        unlock();
        wr(19'h05555, 16'h0080);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0077);
        wr(19'h01000, 16'h0030);
        chk("R7 abort in erase no req", req_seen, 1'b0);
    endtask

    task automatic t_busy_ignore();
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00100, 16'h5A5A);
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00200, 16'h6B6B);
        wr(19'h00000, 16'h00F0);
        chk("R9 no req while busy", req_seen, 1'b0);
        chk("R9 still busy", mode, 2'd3);
        wait_idle();
        wr(19'h00300, 16'h7C7C);
        chk("R9 sequence not advanced by busy beats", req_seen, 1'b0);
    endtask

    task automatic t_edge();
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00400, 16'h0001);
        repeat (P_PROG - 1) @(negedge clk);
        chk("R8 busy in last cycle", mode, 2'd3);
        req_seen = 1'b0;
        wr(19'h05555, 16'h00AA);
        chk("R8 read right after busy", mode, 2'd0);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, 16'h00A0);
        wr(19'h00500, 16'h0002);
        chk("R8 beat in last busy cycle ignored", req_seen, 1'b0);
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00600, 16'h0003);
        repeat (P_PROG) @(negedge clk);
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00700, 16'h0004);
        chk("R8 beat in first free cycle decoded", req_seen, 1'b1);
        wait_idle();
    endtask

    task automatic t_id();
        req_seen = 1'b0;
        unlock();
        wr(19'h05555, 16'h0090);
        chk("R10 id mode", mode, 2'd1);
        rd_addr = 19'h0; #1;
        chk("R10 manufacturer word", rd_data, 16'h00BF);
        rd_addr = 19'h1; #1;
        chk("R10 device word", rd_data, DEV);
        rd_addr = 19'h2; #1;
        chk("R10 other word", rd_data, 16'h0000);
        unlock();
        wr(19'h05555, 16'h00A0);
        wr(19'h00800, 16'h9999);
        chk("R12 program ignored in id mode", req_seen, 1'b0);
        chk("R12 still id mode", mode, 2'd1);
        wr(19'h1_2345, 16'hAAF0);
        chk("R12 single exit", mode, 2'd0);
        rd_addr = 19'h0; #1;
        chk("R1 rd_data zero in read", rd_data, 16'h0000);
    endtask

    task automatic t_query();
        unlock();
        wr(19'h05555, 16'h0098);
        chk("R11 query mode", mode, 2'd2);
        rd_addr = 19'h10; #1;
        chk("R11 query word 0", rd_data, 16'h0051);
        rd_addr = 19'h11; #1;
        chk("R11 query word 1", rd_data, 16'h0052);
        rd_addr = 19'h12; #1;
        chk("R11 query word 2", rd_data, 16'h0059);
        rd_addr = 19'h13; #1;
        chk("R11 query beyond", rd_data, 16'h0000);
        unlock();
        chk("R12 unlock keeps query", mode, 2'd2);
        wr(19'h05555, 16'h00F0);
        chk("R12 three-beat exit", mode, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_sector();
        t_block();
        t_chip();
        t_dont_care();
        wait_idle();
        t_abort();
        t_busy_ignore();
        t_edge();
        t_id();
        t_query();
        finish_up();
    end

endmodule